// File: doc/BRIEF.md
# Scalar Float Compare Flag Unit

This block takes two wide source words, looks only at the single-precision IEEE-754 value held in the low 32 bits of each, and orders them. The outcome (greater, less, equal or unordered) is written into a registered three-bit condition triple made of zero, parity and carry flags. Three further condition outputs (overflow, sign, auxiliary carry) are cleared on every compare that completes.

A mode input picks the NaN policy. In signaling mode any NaN operand raises the invalid condition. In quiet mode only a signaling NaN does. A denormal operand raises the denormal condition. Each condition has its own mask input. A masked condition sets its sticky status bit and lets the flags update. An unmasked condition also sets its sticky bit, but the condition outputs keep their previous values.

A request is a one-cycle `validIn` strobe. One clock later the result registers change and `validOut` pulses.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Only bits [31:0] of `srcA` and `srcB` affect any output. Higher bits are ignored.
- R2: The triple {zf,pf,cf} is 3'b000 when A>B, 3'b001 when A<B, 3'b100 when A==B and 3'b111 when unordered. Ordering is by value, infinities are ordered values, and for two negatives the larger magnitude is the smaller value.
- R3: `ofFlag`, `sfFlag` and `afFlag` are 0 after every completed compare.
- R4: A NaN (exponent 8'hFF, mantissa nonzero) in either operand gives the unordered code.
- R5: -0.0 (32'h80000000) and +0.0 (32'h00000000) compare equal.
- R6: With `signalMode`=1, `excInvalid` is 1 when either operand is any NaN. With `signalMode`=0, it is 1 only when an operand is a signaling NaN (mantissa bit 22 = 0).
- R7: `excDenormal` is 1 when either operand has exponent 0 and a nonzero mantissa.
- R8: If invalid is raised with `invMask`=0, or denormal is raised with `denMask`=0, all six condition outputs keep their previous values.
- R9: A raised condition sets its sticky output (`stickyInvalid`, `stickyDenormal`), which then stays 1 until reset. When every raised condition is masked, the flags update normally.
- R10: `validOut` pulses exactly one cycle after `validIn` and is 0 otherwise. Reset clears the flags, the exception outputs and the sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Compare request strobe |
| srcA | input | SRC_W | First source; low 32 bits hold the value |
| srcB | input | SRC_W | Second source; low 32 bits hold the value |
| signalMode | input | 1 | 1: any NaN is invalid; 0: only signaling NaN is invalid |
| invMask | input | 1 | Masks the invalid condition |
| denMask | input | 1 | Masks the denormal condition |
| validOut | output | 1 | Result pulse, one cycle after request |
| zf | output | 1 | Zero flag of the result triple |
| pf | output | 1 | Parity flag of the result triple |
| cf | output | 1 | Carry flag of the result triple |
| ofFlag | output | 1 | Overflow flag, cleared on compare |
| sfFlag | output | 1 | Sign flag, cleared on compare |
| afFlag | output | 1 | Auxiliary-carry flag, cleared on compare |
| excInvalid | output | 1 | Invalid raised by the last compare |
| excDenormal | output | 1 | Denormal raised by the last compare |
| stickyInvalid | output | 1 | Accumulated invalid status |
| stickyDenormal | output | 1 | Accumulated denormal status |

## Verification
Every result register sits exactly one clock edge behind the request. The flag triple, the cleared flags, both exception outputs, both sticky bits and `validOut` all become visible at the edge that follows the `validIn` cycle. The bench drives each request on a falling edge, drops `validIn` on the next falling edge, and samples every output there, one full edge after capture. It then idles one more cycle and checks that `validOut` has fallen and that the flags have stayed put.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmpRes_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // register exception outputs for this request
    logic updFlags;  // write the condition outputs
    logic setInv;    // invalid raised this request
    logic setDen;    // denormal raised this request
  } ctlStrobe_t;

  // {zf, pf, cf}
  function automatic logic [2:0] flagCode(cmpRes_t r);
    case (r)
      CMP_GT:  flagCode = 3'b000;
      CMP_LT:  flagCode = 3'b001;
      CMP_EQ:  flagCode = 3'b100;
      default: flagCode = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int SRC_W = 128,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_W-1:0] srcA,
  input  logic [SRC_W-1:0] srcB,
  input  ctlStrobe_t       strobe,
  output logic             anyNan,
  output logic             anySnan,
  output logic             anyDen,
  output logic [2:0]       flagTriple,
  output logic [2:0]       extraFlags,
  output logic             excInv,
  output logic             excDen,
  output logic             stickyInv,
  output logic             stickyDen
);
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int MAG_W = EXP_W + MAN_W;

  logic [FP_W-1:0] opVal [2];
  logic [1:0]      isNan, isSnan, isDen, isZero, sgn;
  logic [MAG_W-1:0] mag [2];

  assign opVal[0] = srcA[FP_W-1:0];
  assign opVal[1] = srcB[FP_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_class
    logic [EXP_W-1:0] expF;
    logic [MAN_W-1:0] manF;
    assign expF      = opVal[g][MAG_W-1:MAN_W];
    assign manF      = opVal[g][MAN_W-1:0];
    assign sgn[g]    = opVal[g][FP_W-1];
    assign mag[g]    = opVal[g][MAG_W-1:0];
    assign isNan[g]  = (&expF) && (|manF);
    assign isSnan[g] = isNan[g] && !manF[MAN_W-1];
    assign isDen[g]  = (expF == '0) && (|manF);
    assign isZero[g] = (mag[g] == '0);
  end

  assign anyNan  = |isNan;
  assign anySnan = |isSnan;
  assign anyDen  = |isDen;

  cmpRes_t cmpRes;
  always_comb begin
    if (anyNan)                      cmpRes = CMP_UN;
    else if (&isZero)                cmpRes = CMP_EQ;
    else if (opVal[0] == opVal[1])   cmpRes = CMP_EQ;
    else if (sgn[0] != sgn[1])       cmpRes = sgn[0] ? CMP_LT : CMP_GT;
    else if (mag[0] > mag[1])        cmpRes = sgn[0] ? CMP_LT : CMP_GT;
    else                             cmpRes = sgn[0] ? CMP_GT : CMP_LT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagTriple <= 3'b000;
      extraFlags <= 3'b000;
      excInv     <= 1'b0;
      excDen     <= 1'b0;
      stickyInv  <= 1'b0;
      stickyDen  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        excInv    <= strobe.setInv;
        excDen    <= strobe.setDen;
        stickyInv <= stickyInv | strobe.setInv;
        stickyDen <= stickyDen | strobe.setDen;
      end
      if (strobe.updFlags) begin
        flagTriple <= flagCode(cmpRes);
        extraFlags <= 3'b000;
      end
    end
  end

endmodule

// File: rtl/fcmp_control.sv
module fcmp_control
  import fcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic       signalMode,
  input  logic       invMask,
  input  logic       denMask,
  input  logic       anyNan,
  input  logic       anySnan,
  input  logic       anyDen,
  output ctlStrobe_t strobe,
  output logic       validOut
);
  logic invRaise, denRaise, trapPending;

  assign invRaise    = anySnan || (signalMode && anyNan);
  assign denRaise    = anyDen;
  assign trapPending = (invRaise && !invMask) || (denRaise && !denMask);

  always_comb begin
    strobe.capture  = validIn;
    strobe.updFlags = validIn && !trapPending;
    strobe.setInv   = validIn && invRaise;
    strobe.setDen   = validIn && denRaise;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int SRC_W = 128,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [SRC_W-1:0] srcA,
  input  logic [SRC_W-1:0] srcB,
  input  logic             signalMode,
  input  logic             invMask,
  input  logic             denMask,
  output logic             validOut,
  output logic             zf,
  output logic             pf,
  output logic             cf,
  output logic             ofFlag,
  output logic             sfFlag,
  output logic             afFlag,
  output logic             excInvalid,
  output logic             excDenormal,
  output logic             stickyInvalid,
  output logic             stickyDenormal
);
  ctlStrobe_t strobe;
  logic anyNan, anySnan, anyDen;
  logic [2:0] flagTriple, extraFlags;

  fcmp_control ctl_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .signalMode(signalMode),
    .invMask(invMask), .denMask(denMask), .anyNan(anyNan), .anySnan(anySnan),
    .anyDen(anyDen), .strobe(strobe), .validOut(validOut)
  );

  fcmp_datapath #(.SRC_W(SRC_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) dp_i (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB), .strobe(strobe),
    .anyNan(anyNan), .anySnan(anySnan), .anyDen(anyDen),
    .flagTriple(flagTriple), .extraFlags(extraFlags),
    .excInv(excInvalid), .excDen(excDenormal),
    .stickyInv(stickyInvalid), .stickyDen(stickyDenormal)
  );

  assign {zf, pf, cf}             = flagTriple;
  assign {ofFlag, sfFlag, afFlag} = extraFlags;

endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
  input logic clk,
  input logic rstN,
  input logic validIn,
  input logic invMask,
  input logic denMask,
  input logic validOut,
  input logic zf,
  input logic pf,
  input logic cf,
  input logic ofFlag,
  input logic sfFlag,
  input logic afFlag,
  input logic excInvalid,
  input logic excDenormal,
  input logic stickyInvalid,
  input logic stickyDenormal
);
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

  assert_extra_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !excInvalid && !excDenormal) |-> (!ofFlag && !sfFlag && !afFlag));

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> ({zf, pf, cf} inside {3'b000, 3'b001, 3'b100, 3'b111}));

  assert_hold_on_trap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !invMask && !denMask) |=>
      ((excInvalid || excDenormal) ? $stable({zf, pf, cf, ofFlag, sfFlag, afFlag}) : 1'b1));

  assert_sticky_inv_R9: assert property (@(posedge clk) disable iff (!rstN)
    excInvalid |-> stickyInvalid);

  assert_sticky_den_R9: assert property (@(posedge clk) disable iff (!rstN)
    excDenormal |-> stickyDenormal);

  assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stickyInvalid || stickyDenormal) |=>
      ((stickyInvalid || !$past(stickyInvalid)) && (stickyDenormal || !$past(stickyDenormal))));
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk chk_i (
  .clk(clk), .rstN(rstN), .validIn(validIn), .invMask(invMask), .denMask(denMask),
  .validOut(validOut), .zf(zf), .pf(pf), .cf(cf), .ofFlag(ofFlag), .sfFlag(sfFlag),
  .afFlag(afFlag), .excInvalid(excInvalid), .excDenormal(excDenormal),
  .stickyInvalid(stickyInvalid), .stickyDenormal(stickyDenormal)
);

// File: tb/fcmp_flag_unit_tb_top.sv
module fcmp_flag_unit_tb_top;
  localparam int SRC_W = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic [SRC_W-1:0] srcA = '0, srcB = '0;
  logic signalMode = 1'b0, invMask = 1'b1, denMask = 1'b1;
  logic validOut, zf, pf, cf, ofFlag, sfFlag, afFlag;
  logic excInvalid, excDenormal, stickyInvalid, stickyDenormal;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  fcmp_flag_unit #(.SRC_W(SRC_W)) dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .srcA(srcA), .srcB(srcB),
    .signalMode(signalMode), .invMask(invMask), .denMask(denMask),
    .validOut(validOut), .zf(zf), .pf(pf), .cf(cf), .ofFlag(ofFlag),
    .sfFlag(sfFlag), .afFlag(afFlag), .excInvalid(excInvalid),
    .excDenormal(excDenormal), .stickyInvalid(stickyInvalid),
    .stickyDenormal(stickyDenormal)
  );

  logic [31:0] pats [16];
  initial begin
    pats[0]  = 32'h00000000; pats[1]  = 32'h80000000;
    pats[2]  = 32'h00000001; pats[3]  = 32'h80000001;
    pats[4]  = 32'h007FFFFF; pats[5]  = 32'h3F800000;
    pats[6]  = 32'hBF800000; pats[7]  = 32'h40000000;
    pats[8]  = 32'hC0000000; pats[9]  = 32'h7F7FFFFF;
    pats[10] = 32'hFF7FFFFF; pats[11] = 32'h7F800000;
    pats[12] = 32'hFF800000; pats[13] = 32'h7FC00000;
    pats[14] = 32'h7F800001; pats[15] = 32'hFFC00001;
  end

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit isNanF(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic real valueOf(logic [31:0] v);
    real m;
    int e;
    e = int'(v[30:23]);
    if (e == 255) m = 1.0e300;
    else if (e == 0) m = real'(v[22:0]) * (2.0 ** (-149));
    else m = real'({1'b1, v[22:0]}) * (2.0 ** (e - 150));
    return v[31] ? -m : m;
  endfunction

  logic [2:0] expFlags = 3'b000;
  logic expStInv = 1'b0, expStDen = 1'b0;

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic mode,
                       input logic im, input logic dm);
    bit na, nb, inv, den, trap;
    logic [2:0] code;
    real ra, rb;
    @(negedge clk);
    srcA = {$urandom(), $urandom(), $urandom(), a};  // upper bits are noise (R1)
    srcB = {$urandom(), $urandom(), $urandom(), b};
    signalMode = mode; invMask = im; denMask = dm;
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    na = isNanF(a); nb = isNanF(b);
    ra = valueOf(a); rb = valueOf(b);
    if (na || nb) code = 3'b111;
    else if (ra > rb) code = 3'b000;
    else if (ra < rb) code = 3'b001;
    else code = 3'b100;
    inv = (na && !a[22]) || (nb && !b[22]) || (mode && (na || nb));
    den = (a[30:23] == 0 && a[22:0] != 0) || (b[30:23] == 0 && b[22:0] != 0);
    trap = (inv && !im) || (den && !dm);
    if (!trap) expFlags = code;
    expStInv = expStInv | inv;
    expStDen = expStDen | den;
    check("R10", "validOut", {7'd0, validOut}, 8'd1);
    check("R1 R2 R4 R5 R8 R9", "flags", {5'd0, zf, pf, cf}, {5'd0, expFlags});
    check("R3", "extra", {5'd0, ofFlag, sfFlag, afFlag}, 8'd0);
    check("R6", "excInvalid", {7'd0, excInvalid}, {7'd0, inv});
    check("R7", "excDenormal", {7'd0, excDenormal}, {7'd0, den});
    check("R9", "stickies", {6'd0, stickyInvalid, stickyDenormal},
          {6'd0, expStInv, expStDen});
    @(negedge clk);
    check("R10", "idle validOut", {7'd0, validOut}, 8'd0);
    check("R10", "idle flags", {5'd0, zf, pf, cf}, {5'd0, expFlags});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "reset validOut", {7'd0, validOut}, 8'd0);
    check("R10", "reset flags", {2'd0, zf, pf, cf, ofFlag, sfFlag, afFlag}, 8'd0);
    check("R10", "reset exc", {4'd0, excInvalid, excDenormal, stickyInvalid, stickyDenormal}, 8'd0);
    // masked sweep first, so stickies start clean and flags update
    for (int mode = 0; mode < 2; mode++)
      for (int mk = 3; mk >= 0; mk--)
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 16; j++)
            runOp(pats[i], pats[j], mode[0], mk[1], mk[0]);
    // explicit corners
    runOp(32'h80000000, 32'h00000000, 1'b0, 1'b1, 1'b1);  // R5
    runOp(32'hC0000000, 32'hBF800000, 1'b0, 1'b1, 1'b1);  // R2 negatives
    runOp(32'h7F800000, 32'h7F7FFFFF, 1'b0, 1'b1, 1'b1);  // R2 infinity
    runOp(32'h3F800000, 32'h7FC00000, 1'b0, 1'b0, 1'b1);  // R6 quiet, QNaN: no trap
    runOp(32'h3F800000, 32'h7FC00000, 1'b1, 1'b0, 1'b1);  // R8 trap holds
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule